// File: doc/BRIEF.md
# Transmit Buffer with Start Threshold

This block sits between a byte-wide packet source and a byte-wide MAC transmit path. Bytes enter on a valid/ready stream with an end-of-frame marker and are stored back-to-back in a 1024-byte buffer. A frame is not released toward the MAC until enough data has built up. The amount is a programmed number of 16-byte ticks. A frame is also released once its end-of-frame byte is stored. Holding frames back this way keeps the MAC from running dry in the middle of a frame.

The write side applies back-pressure only when the buffer is full: `in_ready` is low while 1024 bytes are held, and a byte is taken on every edge where `in_valid` and `in_ready` are both high. The MAC side has no back-pressure. Once a frame starts, one byte leaves per cycle with `out_valid` high until the beat carrying `out_last`. If the buffer empties before that, the frame is cut short with an error beat. The rest of that frame is then discarded, and a sticky underflow flag is raised. This flag has its own write-1-to-clear input and an enable that gates the interrupt output.

The threshold register is written through a plain write strobe. Out-of-range values are clamped. The register is copied into the start logic only while no frame is being sent.

Top module: `tx_start_fifo`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, `uf_pending` and `uf_irq` are 0, and the threshold is 32 ticks (512 bytes).
- R2: Bytes leave in the order they were written, and `out_last` is high on exactly the byte written with `in_eof`.
- R3: While idle, a frame starts (first `out_valid`) one cycle after the edge where the stored byte count reaches threshold x 16. It never starts earlier unless a complete frame is stored.
- R4: A frame shorter than the threshold starts one cycle after the edge that stores its `in_eof` byte.
- R5: A programmed threshold below 4 ticks behaves as 4 ticks (64 bytes).
- R6: A programmed threshold above 64 ticks behaves as 64 ticks (1024 bytes, the whole buffer).
- R7: `in_ready` falls in the cycle after the 1024th stored byte. No byte is accepted while it is low.
- R8: Once `out_valid` rises it stays high every cycle until the beat with `out_last`.
- R9: If the buffer is empty during a started frame, one beat is sent with `out_last`=1, `out_err`=1 and `out_data`=0. The remaining bytes of that frame, up to and including its `in_eof` byte, are then dropped without any `out_valid`. With no starvation, `out_err` never rises.
- R10: An error beat sets `uf_pending` on the next edge. It stays set until a cycle with `uf_clr`=1 (a set in the same cycle wins).
- R11: `uf_irq` equals `uf_pending` AND `uf_en`.
- R12: A threshold write made while a frame is being sent leaves that frame's drain unbroken. The new value governs the next start decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source has a byte |
| in_ready | output | 1 | Buffer can take a byte (low when full) |
| in_data | input | 8 | Byte from source |
| in_eof | input | 1 | Byte is the last of its frame |
| out_valid | output | 1 | Beat toward the MAC this cycle |
| out_data | output | 8 | Byte toward the MAC |
| out_last | output | 1 | Last beat of the frame |
| out_err | output | 1 | Frame cut short by underflow |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 8 | Threshold in 16-byte ticks |
| uf_en | input | 1 | Underflow interrupt enable |
| uf_clr | input | 1 | Clear underflow flag (write 1) |
| uf_pending | output | 1 | Sticky underflow flag |
| uf_irq | output | 1 | Gated underflow interrupt |

## Verification
The bench targets the exact start cycle at the default threshold, at both clamp limits and for a frame shorter than the threshold. A design that compared against the raw value, or was off by one register, would start a cycle early or late, or would deadlock with a full buffer. It starves a started frame on purpose. A design that mishandled this would repeat stale bytes, omit the error beat, or leak the rest of the broken frame onto the MAC side. It also checks that the flag ignores the enable but the interrupt does not. A threshold write in mid-frame must not break the drain. Random back-to-back frames with random thresholds confirm that order and frame boundaries hold, and that no false underflow appears.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DROP = 2'd2
  } tsf_state_e;
endpackage

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic [CW-1:0] level,
  output logic [CW-1:0] frames,
  output logic          full,
  output logic          empty
);
  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  // pointer advance: free wrap for power-of-two depth, explicit wrap otherwise
  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      frames <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_nxt;
      if (rd_en) rd_ptr <= rd_nxt;
      level  <= level + CW'(wr_en) - CW'(rd_en);
      frames <= frames + CW'(wr_en & wr_last) - CW'(rd_en & rd_last);
    end
  end

  assign {rd_last, rd_data} = mem[rd_ptr];
  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);

  // R7: occupancy never passes the depth
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R7: a full buffer takes no byte on the next edge
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_en |=> full);
  // R2: complete frames can never outnumber stored bytes
  assert_frames_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frames <= level);
endmodule

// File: rtl/tsf_thresh.sv
module tsf_thresh #(
  parameter int CFG_W      = 8,
  parameter int TICK_BYTES = 16,
  parameter int MIN_TICKS  = 4,
  parameter int MAX_TICKS  = 64,
  parameter int RST_TICKS  = 32,
  parameter int CW         = 11,
  localparam int TW        = $clog2(MAX_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_val,
  input  logic             idle,
  output logic [CW-1:0]    thr_bytes
);
  logic [TW-1:0] clamped, prog_q, live_q;

  always_comb begin
    if (cfg_val < CFG_W'(MIN_TICKS))      clamped = TW'(MIN_TICKS);
    else if (cfg_val > CFG_W'(MAX_TICKS)) clamped = TW'(MAX_TICKS);
    else                                  clamped = cfg_val[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q <= TW'(RST_TICKS);
      live_q <= TW'(RST_TICKS);
    end else begin
      if (cfg_we) prog_q <= clamped;
      if (idle)   live_q <= prog_q;
    end
  end

  assign thr_bytes = CW'(live_q) * CW'(TICK_BYTES);

  // R5 / R6: the value used for start decisions stays inside the legal range
  assert_thr_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q >= TW'(MIN_TICKS));
  assert_thr_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q <= TW'(MAX_TICKS));
  // R12: the start threshold is frozen while a frame is on the wire
  assert_thr_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(live_q));
endmodule

// File: rtl/tsf_sched.sv
module tsf_sched
  import tsf_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] frames,
  input  logic          empty,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_last,
  input  logic [CW-1:0] thr_bytes,
  input  logic          uf_clr,
  input  logic          uf_en,
  output logic          rd_en,
  output logic          idle,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          out_err,
  output logic          uf_pending,
  output logic          uf_irq
);
  tsf_state_e st, nxt;
  logic       uf_hit;

  always_comb begin
    nxt       = st;
    rd_en     = 1'b0;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    out_err   = 1'b0;
    uf_hit    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (frames != '0 || level >= thr_bytes) nxt = ST_SEND;
      end
      ST_SEND: begin
        out_valid = 1'b1;
        if (empty) begin
          out_last = 1'b1;
          out_err  = 1'b1;
          uf_hit   = 1'b1;
          nxt      = ST_DROP;
        end else begin
          rd_en    = 1'b1;
          out_data = rd_data;
          out_last = rd_last;
          if (rd_last) nxt = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (!empty) begin
          rd_en = 1'b1;
          if (rd_last) nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      uf_pending <= 1'b0;
    end else begin
      st <= nxt;
      if (uf_hit)      uf_pending <= 1'b1;
      else if (uf_clr) uf_pending <= 1'b0;
    end
  end

  assign idle   = (st == ST_IDLE);
  assign uf_irq = uf_pending & uf_en;

  // R3 / R4: a frame starts only after the threshold or a whole frame is held
  assert_start_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frames != '0 || level >= thr_bytes));
  // R8: no gap inside a started frame
  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);
  // R9: an error beat always closes the frame
  assert_err_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid && out_last);
  // R10: starvation leaves the sticky flag set
  assert_flag_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |=> uf_pending);
  // R11: the interrupt never fires while disabled
  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    uf_irq |-> uf_en);
endmodule

// File: rtl/tx_start_fifo.sv
module tx_start_fifo #(
  parameter int DW          = 8,
  parameter int CFG_W       = 8,
  parameter int TICK_BYTES  = 16,
  parameter int DEPTH_TICKS = 64,
  parameter int MIN_TICKS   = 4,
  parameter int RST_TICKS   = 32,
  localparam int DEPTH      = TICK_BYTES * DEPTH_TICKS,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_eof,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             out_err,
  input  logic             thr_we,
  input  logic [CFG_W-1:0] thr_wdata,
  input  logic             uf_en,
  input  logic             uf_clr,
  output logic             uf_pending,
  output logic             uf_irq
);
  logic          full, empty, rd_en, rd_last, idle, wr_en;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] level, frames, thr_bytes;

  assign in_ready = ~full;
  assign wr_en    = in_valid & ~full;

  tsf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk, .rst_n,
    .wr_en, .wr_data(in_data), .wr_last(in_eof),
    .rd_en, .rd_data, .rd_last,
    .level, .frames, .full, .empty
  );

  tsf_thresh #(
    .CFG_W(CFG_W), .TICK_BYTES(TICK_BYTES), .MIN_TICKS(MIN_TICKS),
    .MAX_TICKS(DEPTH_TICKS), .RST_TICKS(RST_TICKS), .CW(CW)
  ) u_thresh (
    .clk, .rst_n,
    .cfg_we(thr_we), .cfg_val(thr_wdata), .idle, .thr_bytes
  );

  tsf_sched #(.DW(DW), .CW(CW)) u_sched (
    .clk, .rst_n,
    .level, .frames, .empty, .rd_data, .rd_last, .thr_bytes,
    .uf_clr, .uf_en,
    .rd_en, .idle,
    .out_valid, .out_data, .out_last, .out_err,
    .uf_pending, .uf_irq
  );
endmodule

// File: tb/tb_tx_start_fifo.sv
`timescale 1ns/1ps
module tb_tx_start_fifo;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, in_eof = 1'b0, thr_we = 1'b0, uf_en = 1'b0, uf_clr = 1'b0;
  logic [7:0] in_data = '0, thr_wdata = '0;
  logic       in_ready, out_valid, out_last, out_err, uf_pending, uf_irq;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0;
  logic [9:0] exp_q[$];   // {err, last, data}
  bit   mid = 1'b0;
  int   first_stall = -1;

  always #5 clk = ~clk;

  tx_start_fifo dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_eof,
    .out_valid, .out_data, .out_last, .out_err,
    .thr_we, .thr_wdata, .uf_en, .uf_clr, .uf_pending, .uf_irq
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [7:0] byte_of(input int base, input int i);
    return 8'(base + i * 7);
  endfunction

  // R2 R8 R9: scoreboard on the MAC side
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected beat", {out_err, out_last, out_data}, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({out_err, out_last, out_data} === e, e[9] ? "R9" : "R2", "beat",
              {out_err, out_last, out_data}, e);
        end
      end else if (mid) begin
        chk(1'b0, "R8", "gap inside frame", 0, 1);
      end
      mid = out_valid && !out_last;
    end
  end

  task automatic exp_frame(input int len, input int base);
    for (int i = 0; i < len; i++) exp_q.push_back({1'b0, i == len - 1, byte_of(base, i)});
  endtask

  // writes len bytes; if chk_t>0, out_valid must rise exactly one cycle after
  // the stored count reaches chk_t
  task automatic push_bytes(input int len, input int base, input int chk_t,
                            input bit eof, input string req);
    int a = 0;
    bit hit = 0, bad = 0, rdy;
    first_stall = -1;
    while (a < len) begin
      @(negedge clk);
      if (chk_t > 0) begin
        if (out_valid !== hit) bad = 1;
        if (a >= chk_t) hit = 1;
      end
      in_valid = 1'b1;
      in_data  = byte_of(base, a);
      in_eof   = eof && (a == len - 1);
      rdy = in_ready;
      if (!rdy && first_stall < 0) first_stall = a;
      @(posedge clk);
      if (rdy) a++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_eof   = 1'b0;
    if (chk_t > 0) chk(!bad, req, "start cycle vs threshold", bad, 0);
  endtask

  task automatic prog(input int v);
    @(negedge clk);
    thr_we = 1'b1; thr_wdata = 8'(v);
    @(negedge clk);
    thr_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(input int extra);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
    chk(uf_pending == 0, "R1", "uf_pending", uf_pending, 0);
    chk(uf_irq == 0, "R1", "uf_irq", uf_irq, 0);

    // R1 R3: default threshold 512 bytes
    exp_frame(600, 3);
    push_bytes(600, 3, 512, 1, "R3");
    drain(4);

    // R4: short frame released one cycle after its eof byte
    exp_frame(20, 90);
    push_bytes(20, 90, 512, 1, "R4");
    chk(out_valid == 0, "R4", "no start on eof edge", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R4", "start after eof", out_valid, 1);
    drain(4);

    // R5: value below floor acts as 4 ticks
    prog(1);
    exp_frame(150, 17);
    push_bytes(150, 17, 64, 1, "R5");
    drain(4);

    // R6 R7: value above ceiling acts as the whole buffer
    prog(200);
    exp_frame(1100, 55);
    push_bytes(1100, 55, 1024, 1, "R6");
    chk(first_stall == 1024, "R7", "in_ready fell at full", first_stall, 1024);
    drain(4);

    // R12: threshold write during a frame does not disturb it
    prog(4);
    exp_frame(300, 7);
    fork
      push_bytes(300, 7, 64, 1, "R12");
      begin
        repeat (120) @(negedge clk);
        thr_we = 1'b1; thr_wdata = 8'd10;
        @(negedge clk);
        thr_we = 1'b0;
      end
    join
    drain(4);
    exp_frame(200, 33);
    push_bytes(200, 33, 160, 1, "R12");
    drain(4);

    // R9 R10 R11: starve a started frame
    prog(4);
    uf_en = 1'b0;
    exp_frame(64, 200);
    exp_q[$] = {1'b0, 1'b0, byte_of(200, 63)};
    exp_q.push_back(10'b11_0000_0000);
    push_bytes(64, 200, 64, 0, "R9");
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "error beat seen", exp_q.size(), 0);
    chk(uf_pending == 1, "R10", "flag set", uf_pending, 1);
    chk(uf_irq == 0, "R11", "irq masked", uf_irq, 0);
    uf_en = 1'b1;
    @(negedge clk);
    chk(uf_irq == 1, "R11", "irq enabled", uf_irq, 1);
    push_bytes(36, 264, 0, 1, "R9");   // remainder must be dropped
    repeat (10) @(negedge clk);
    chk(uf_pending == 1, "R10", "flag held", uf_pending, 1);
    uf_clr = 1'b1;
    @(negedge clk);
    uf_clr = 1'b0;
    chk(uf_pending == 0, "R10", "flag cleared", uf_pending, 0);
    chk(uf_irq == 0, "R11", "irq cleared", uf_irq, 0);
    exp_frame(10, 77);
    push_bytes(10, 77, 0, 1, "R9");
    drain(6);

    // random back-to-back frames with random thresholds
    for (int f = 0; f < 40; f++) begin
      int len, base;
      if ($urandom % 4 == 0) prog($urandom % 80);
      len  = 1 + int'($urandom % 300);
      base = int'($urandom % 256);
      exp_frame(len, base);
      push_bytes(len, base, 0, 1, "R2");
      repeat ($urandom % 4) @(negedge clk);
    end
    drain(8);
    chk(uf_pending == 0, "R9", "no false underflow", uf_pending, 0);
    chk(exp_q.size() == 0, "R2", "all bytes delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule